// File: doc/BRIEF.md
# Shadow-Register BCD Real-Time Clock

This block keeps time of day and calendar date in packed BCD and presents it to software through a small parallel register bus. It holds two copies of the time. A live set of counters advances once per second, driven by a prescaler that divides the system clock. A user-visible set of copies sits on the bus. On the clock cycle after each one-second advance, every live field is copied into the user copies together, so software never sees a partly updated time.

Two control bits suspend that copy. The snapshot bit freezes the user copies so that a multi-byte read stays consistent while the live counters keep running. The set bit also freezes the copies, so software can write a new time into them. When the set bit goes from 1 back to 0, all user time fields are loaded into the live counters in a single cycle. A stop bit in the seconds register halts the prescaler, and no write sequence is needed to change it.

Top module: `rtc_shadow_top`

## Requirements
- R1: After reset the control register reads 0x00 (set and snapshot clear), STOP is 0, and the time reads seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00, century 0x20.
- R2: Register offsets: 0x8 control, 0x9 seconds (bit 7 = STOP), 0xA minutes, 0xB hours, 0xC weekday, 0xD date, 0xE month, 0xF year, 0x1 century; every other offset reads 0x00. bus_rdata takes the addressed value on the clock edge where bus_rd is high and holds it while bus_rd is low.
- R3: The live counters advance one second every TICK_DIV clock cycles, and every user time field takes the new live value on the following edge, all in the same cycle.
- R4: Seconds and minutes wrap from 0x59 to 0x00 with a carry, and hours wrap from 0x23 to 0x00 with a carry into the day.
- R5: On a day carry the weekday goes 0x07 to 0x01 (otherwise +1), and the date wraps to 0x01 after the last day of the month (30 for months 04, 06, 09, 11; 29 for month 02 when the BCD year is a multiple of 4, else 28; 31 otherwise), carrying into the month, which wraps 0x12 to 0x01.
- R6: A month carry from 0x12 wraps the year 0x99 to 0x00 and increments the century.
- R7: While control bit 6 (snapshot) is 1 the user copies keep their value while the live counters keep counting; after it returns to 0 the user copies stay unchanged until the next advance, then show the live time.
- R8: A snapshot request written on the same edge as a pending copy does not stop that copy.
- R9: While control bit 7 (set) is 1 no copy reaches the user copies, so written values persist; writing control with bit 7 = 0 while set is 1 loads every user time field into the live counters on that edge and restarts the prescaler, so the next advance comes TICK_DIV cycles later.
- R10: A write to a time register while neither freeze bit is set changes only the user copy, which the next copy overwrites with the live value.
- R11: Writing seconds with bit 7 = 1 sets STOP, which reads back in bit 7, halts the counters without the set bit, and holds the prescaler at zero; writing 0 restarts it and the next advance comes TICK_DIV cycles after that write.
- R12: Control bits 5 to 0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, loads bus_rdata on the edge |
| bus_rdata | output | 8 | Registered read data |

## Verification
A wrong live counter stays hidden until the next copy, so it shows at the ports one cycle after the following one-second advance, and a wrong carry shows only when the tests place the time just below a rollover boundary. A freeze bit latched incorrectly shows as a seconds value that differs by one from the time kept in the bench, either a copy dropped on the very edge of a snapshot request or a copy leaking through while frozen. A prescaler that is not restarted by a load or by clearing STOP shows as an advance visible one read early or late, which the tests catch by reading just before and just after the expected advance.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CENT  = 4'h1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'h8;
    localparam logic [ADDR_W-1:0] A_SECS  = 4'h9;
    localparam logic [ADDR_W-1:0] A_MINS  = 4'hA;
    localparam logic [ADDR_W-1:0] A_HOURS = 4'hB;
    localparam logic [ADDR_W-1:0] A_WDAY  = 4'hC;
    localparam logic [ADDR_W-1:0] A_DATE  = 4'hD;
    localparam logic [ADDR_W-1:0] A_MONTH = 4'hE;
    localparam logic [ADDR_W-1:0] A_YEAR  = 4'hF;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hours;
        logic [7:0] mins;
        logic [7:0] secs;
    } rtc_time_t;

    localparam rtc_time_t TIME_RST = '{cent: 8'h20, year: 8'h00, month: 8'h01,
                                       date: 8'h01, wday: 8'h01, hours: 8'h00,
                                       mins: 8'h00, secs: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic is_leap(input logic [7:0] y);
        logic [6:0] b;
        b = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
        logic [7:0] r;
        case (m)
            8'h02:                      r = is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICK_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic tick_o
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i)                 st_d.cnt = '0;
        else if (st_q.cnt == CNT_MAX) st_d.cnt = '0;
        else                        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = (st_q.cnt == CNT_MAX) && !hold_i;

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    p_hold_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (st_q.cnt == '0));

    generate
        if (TICK_DIV > 1) begin : g_gap
            p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      load_i,
    input  rtc_time_t load_val_i,
    output rtc_time_t time_o
);
    typedef struct packed {
        rtc_time_t t;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    rtc_time_t  adv;

    always_comb begin
        logic c_min, c_hr, c_day, c_mon, c_yr;
        adv   = st_q.t;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;

        if (st_q.t.secs == 8'h59) begin
            adv.secs = 8'h00;
            c_min    = 1'b1;
        end else begin
            adv.secs = bcd_inc(st_q.t.secs);
        end

        if (c_min) begin
            if (st_q.t.mins == 8'h59) begin
                adv.mins = 8'h00;
                c_hr     = 1'b1;
            end else begin
                adv.mins = bcd_inc(st_q.t.mins);
            end
        end

        if (c_hr) begin
            if (st_q.t.hours == 8'h23) begin
                adv.hours = 8'h00;
                c_day     = 1'b1;
            end else begin
                adv.hours = bcd_inc(st_q.t.hours);
            end
        end

        if (c_day) begin
            adv.wday = (st_q.t.wday == 8'h07) ? 8'h01 : bcd_inc(st_q.t.wday);
            if (st_q.t.date == month_len(st_q.t.month, st_q.t.year)) begin
                adv.date = 8'h01;
                c_mon    = 1'b1;
            end else begin
                adv.date = bcd_inc(st_q.t.date);
            end
        end

        if (c_mon) begin
            if (st_q.t.month == 8'h12) begin
                adv.month = 8'h01;
                c_yr      = 1'b1;
            end else begin
                adv.month = bcd_inc(st_q.t.month);
            end
        end

        if (c_yr) begin
            if (st_q.t.year == 8'h99) begin
                adv.year = 8'h00;
                adv.cent = (st_q.t.cent == 8'h99) ? 8'h00 : bcd_inc(st_q.t.cent);
            end else begin
                adv.year = bcd_inc(st_q.t.year);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.t         = load_val_i;
            st_d.t.secs[7] = 1'b0;
        end else if (tick_i) begin
            st_d.t = adv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.t <= TIME_RST;
        else        st_q   <= st_d;
    end

    assign time_o = st_q.t;

    p_sec_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !load_i |=> time_o.secs != $past(time_o.secs));

    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !load_i && (time_o.secs == 8'h59) |=> (time_o.secs == 8'h00));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !load_i |=> $stable(time_o));

    p_load_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (time_o.mins == $past(load_val_i.mins)) && (time_o.year == $past(load_val_i.year)));

endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              tick_i,
    input  rtc_time_t         live_i,
    output rtc_time_t         user_o,
    output logic              stop_o,
    output logic              load_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        rtc_time_t         sh;
        logic              snap;
        logic              set;
        logic              stop;
        logic              pend;
        logic [DATA_W-1:0] rdata;
    } sh_state_t;

    sh_state_t         st_d, st_q;
    logic              frozen;
    logic [DATA_W-1:0] rd_mux;

    assign frozen = st_q.snap || st_q.set;

    always_comb begin
        case (addr_i)
            A_CTRL:  rd_mux = {st_q.set, st_q.snap, 6'b0};
            A_SECS:  rd_mux = {st_q.stop, st_q.sh.secs[6:0]};
            A_MINS:  rd_mux = st_q.sh.mins;
            A_HOURS: rd_mux = st_q.sh.hours;
            A_WDAY:  rd_mux = st_q.sh.wday;
            A_DATE:  rd_mux = st_q.sh.date;
            A_MONTH: rd_mux = st_q.sh.month;
            A_YEAR:  rd_mux = st_q.sh.year;
            A_CENT:  rd_mux = st_q.sh.cent;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = tick_i;
        if (st_q.pend && !frozen) begin
            st_d.sh         = live_i;
            st_d.sh.secs[7] = 1'b0;
        end
        if (wr_i) begin
            case (addr_i)
                A_CTRL: begin
                    st_d.set  = wdata_i[7];
                    st_d.snap = wdata_i[6];
                end
                A_SECS: begin
                    st_d.stop    = wdata_i[7];
                    st_d.sh.secs = {1'b0, wdata_i[6:0]};
                end
                A_MINS:  st_d.sh.mins  = wdata_i;
                A_HOURS: st_d.sh.hours = wdata_i;
                A_WDAY:  st_d.sh.wday  = wdata_i;
                A_DATE:  st_d.sh.date  = wdata_i;
                A_MONTH: st_d.sh.month = wdata_i;
                A_YEAR:  st_d.sh.year  = wdata_i;
                A_CENT:  st_d.sh.cent  = wdata_i;
                default: ;
            endcase
        end
        if (rd_i) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh    <= TIME_RST;
            st_q.snap  <= 1'b0;
            st_q.set   <= 1'b0;
            st_q.stop  <= 1'b0;
            st_q.pend  <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o  = wr_i && (addr_i == A_CTRL) && !wdata_i[7] && st_q.set;
    assign user_o  = st_q.sh;
    assign stop_o  = st_q.stop;
    assign rdata_o = st_q.rdata;

    p_frozen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !wr_i |=> $stable(st_q.sh));

    p_copy_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend && !frozen && !wr_i |=>
            (st_q.sh.mins == $past(live_i.mins)) && (st_q.sh.date == $past(live_i.date)));

    p_load_ends_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !st_q.set);

    p_ctrl_low_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i && (addr_i == A_CTRL) |=> (rdata_o[5:0] == 6'b0));

endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top
    import rtc_pkg::*;
#(
    parameter int TICK_DIV = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata
);
    logic      tick;
    logic      load;
    logic      stop;
    logic      pre_hold;
    rtc_time_t live_t;
    rtc_time_t user_t;

    assign pre_hold = stop || load;

    rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (pre_hold),
        .tick_o (tick)
    );

    rtc_counters u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load),
        .load_val_i (user_t),
        .time_o     (live_t)
    );

    rtc_shadow u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .tick_i  (tick),
        .live_i  (live_t),
        .user_o  (user_t),
        .stop_o  (stop),
        .load_o  (load),
        .rdata_o (bus_rdata)
    );

    p_stop_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> !tick);

endmodule

// File: tb/sim_rtc_shadow_top.sv
module sim_rtc_shadow_top;
    localparam int DIV = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_shadow_top #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, wd, dt, mo, y, ce, output int e);
        bus_write(4'h8, 8'h80);
        bus_write(4'h9, s);  bus_write(4'hA, mi); bus_write(4'hB, h);
        bus_write(4'hC, wd); bus_write(4'hD, dt); bus_write(4'hE, mo);
        bus_write(4'hF, y);  bus_write(4'h1, ce);
        bus_write(4'h8, 8'h00);
        e = cyc;
    endtask

    task automatic t_reset;
        read_chk(4'h9, 8'h00, "R1 seconds");
        read_chk(4'h8, 8'h00, "R1 R12 control");
        read_chk(4'hA, 8'h00, "R1 minutes");
        read_chk(4'hB, 8'h00, "R1 hours");
        read_chk(4'hC, 8'h01, "R1 weekday");
        read_chk(4'hD, 8'h01, "R1 date");
        read_chk(4'hE, 8'h01, "R1 month");
        read_chk(4'hF, 8'h00, "R1 year");
        read_chk(4'h0, 8'h00, "R2 unused 0x0");
        read_chk(4'h2, 8'h00, "R2 unused 0x2");
        read_chk(4'h1, 8'h20, "R1 century");
        @(negedge clk); bus_addr = 4'h8;
        @(negedge clk);
        chk("R2 rdata holds without strobe", bus_rdata, 8'h20);
    endtask

    task automatic t_tick;
        int e;
        set_time(8'h56, 8'h34, 8'h12, 8'h03, 8'h15, 8'h06, 8'h31, 8'h20, e);
        wait_until(e + DIV/2);
        read_chk(4'h9, 8'h56, "R3 before first advance");
        wait_until(e + DIV - 3);
        read_chk(4'h9, 8'h56, "R9 prescaler restarted by load");
        wait_until(e + DIV + DIV/2);
        read_chk(4'h9, 8'h57, "R3 one advance");
        read_chk(4'hA, 8'h34, "R3 minutes kept");
    endtask

    task automatic t_rollover;
        int e;
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h20, e);
        wait_until(e + 2*DIV + 1);
        read_chk(4'h9, 8'h00, "R4 seconds wrap");
        read_chk(4'hA, 8'h00, "R4 minutes wrap");
        read_chk(4'hB, 8'h00, "R4 hours wrap");
        read_chk(4'hC, 8'h01, "R5 weekday 7 to 1");
        read_chk(4'hD, 8'h01, "R5 date wrap");
        read_chk(4'hE, 8'h01, "R5 month 12 to 1");
        read_chk(4'hF, 8'h00, "R6 year wrap");
        read_chk(4'h1, 8'h21, "R6 century carry");
    endtask

    task automatic t_month_len;
        int e;
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24, 8'h20, e);
        wait_until(e + DIV + 2);
        read_chk(4'hD, 8'h29, "R5 leap Feb 29");
        read_chk(4'hE, 8'h02, "R5 leap month kept");
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h20, e);
        wait_until(e + DIV + 2);
        read_chk(4'hD, 8'h01, "R5 non-leap Feb wrap");
        read_chk(4'hE, 8'h03, "R5 non-leap to March");
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h23, 8'h20, e);
        wait_until(e + DIV + 2);
        read_chk(4'hD, 8'h01, "R5 30-day month wrap");
        read_chk(4'hE, 8'h05, "R5 April to May");
    endtask

    task automatic t_snapshot;
        int e;
        set_time(8'h10, 8'h00, 8'h08, 8'h01, 8'h10, 8'h03, 8'h30, 8'h20, e);
        wait_until(e + DIV - 1);
        bus_write(4'h8, 8'h40);
        wait_until(e + 3*DIV + 10);
        read_chk(4'h9, 8'h11, "R8 copy on freeze edge kept, R7 frozen");
        read_chk(4'h8, 8'h40, "R7 snapshot bit reads back");
        bus_write(4'h8, 8'h00);
        read_chk(4'h9, 8'h11, "R7 no copy before next advance");
        wait_until(e + 5*DIV);
        read_chk(4'h9, 8'h15, "R7 live time after release");
    endtask

    task automatic t_write_paths;
        int e, e2;
        set_time(8'h00, 8'h05, 8'h09, 8'h01, 8'h10, 8'h03, 8'h30, 8'h20, e);
        wait_until(e + 2);
        bus_write(4'hA, 8'h33);
        read_chk(4'hA, 8'h33, "R10 user copy written");
        wait_until(e + DIV + 5);
        read_chk(4'hA, 8'h05, "R10 overwritten by copy");
        bus_write(4'h8, 8'h80);
        bus_write(4'hA, 8'h42);
        repeat (2*DIV) @(negedge clk);
        read_chk(4'hA, 8'h42, "R9 held while set");
        bus_write(4'h8, 8'h00);
        e2 = cyc;
        wait_until(e2 + DIV + 3);
        read_chk(4'hA, 8'h42, "R9 minutes loaded");
        read_chk(4'h9, 8'h02, "R9 seconds loaded then advanced");
    endtask

    task automatic t_stop;
        int e, s;
        set_time(8'h20, 8'h00, 8'h10, 8'h01, 8'h10, 8'h03, 8'h30, 8'h20, e);
        bus_write(4'h9, 8'hA0);
        wait_until(e + 3*DIV);
        read_chk(4'h9, 8'hA0, "R11 stopped, bit 7 set");
        read_chk(4'h8, 8'h00, "R11 no set bit needed");
        bus_write(4'h9, 8'h20);
        s = cyc;
        wait_until(s + DIV - 3);
        read_chk(4'h9, 8'h20, "R11 full period after restart");
        wait_until(s + DIV + 2);
        read_chk(4'h9, 8'h21, "R11 counting resumed");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tick();
        t_rollover();
        t_month_len();
        t_snapshot();
        t_write_paths();
        t_stop();
        finish_run();
    end

endmodule